// File: doc/BRIEF.md
# Receive Coexistence Status Generator

This block sits beside a WLAN receive path and turns its PHY and MAC events into 64-bit coexistence status messages. A neighbouring radio arbiter uses these messages to see what the receiver is doing and how long the current exchange will last. The PHY side reports the start of a PPDU with its rate, bandwidth, stream count, RSSI and expected airtime. It also reports a normal end and an end caused by a nap abort. The MAC side delivers the result of each MPDU header: filter pass, addressed to this station, A-MPDU, frame type, retry, more-data and whether a response is expected. It also delivers FCS-good pulses that carry the frame's duration field.

Within one PPDU the block emits at most one start message and at most one first-good-FCS message, and an end message only if a start message went out. Word 1 of each message carries a remaining-airtime counter and a remaining-exchange-time value. The counter counts down on a microsecond tick. The exchange time is the airtime plus the duration field of the first good FCS. Messages leave over a valid/ready handshake. A one-entry holding register absorbs backpressure, and end messages take precedence in it.

Top module: `rx_coex_status_gen`

## Requirements
- R1: Bits [1:0] of every message carry the status code: 0 start, 1 first good FCS, 2 normal end, 3 end by nap abort. A cycle with both end pulses reports code 3.
- R2: After a PPDU start, the first header that qualifies produces a start message. When the filtered-out option is clear, a header qualifies only if it passes the filter and is directed. Later headers in the same PPDU produce no message.
- R3: Bit [2] is 0 in start messages. In FCS and end messages it is the OR of the response-expected bits of all filtered-in directed headers seen in the PPDU before that message.
- R4: Word 0 layout: rate [7:3], bandwidth [10:8], single-MPDU [11], filter status [12], A-MPDU [13], directed [14], bit [15] always 0, streams minus one [18:16], RSSI [26:19], frame type [29:27], retry [30], more-data [31]. Header fields come from the header that triggered the start message.
- R5: When the filtered-out option is set, the first header of any kind triggers the start message, with filter status, A-MPDU and directed copied from it. When the option is clear, those three fields are 0.
- R6: A first-good-FCS message (code 1) goes out at most once per PPDU. It requires an FCS-good pulse marked as directed, a start message already sent, and an A-MPDU triggering header.
- R7: Word 1 [15:0] holds the remaining airtime. It is loaded at PPDU start, drops by one on each tick cycle and stops at 0. A message shows the value from before that cycle's tick.
- R8: Word 1 [31:16] equals the airtime until the first FCS-good pulse of the PPDU, whether directed or not. From that pulse on, it equals the airtime plus that pulse's duration, saturating at 0xFFFF.
- R9: An end or nap pulse with no start message sent produces no message. Any end or nap pulse closes the PPDU. Headers, FCS pulses and end pulses are then ignored until the next PPDU start, which clears all one-shot state.
- R10: While out_valid is high and out_ready is low, out_valid and out_msg hold their values.
- R11: Under backpressure, one further message waits in a holding register. When the holding register is full, an incoming end message (code 2 or 3) replaces its contents and any other message is dropped. Waiting messages leave in order.
- R12: During and right after reset, out_valid is 0.
- R13: If an end pulse and a header or FCS pulse arrive in the same cycle, only the end is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_report_filtered | input | 1 | Report filtered-out frames and fill filter/A-MPDU/directed fields |
| phy_start | input | 1 | PPDU start pulse |
| phy_rate | input | 5 | Receive rate at start |
| phy_bw | input | 3 | Bandwidth code (0:20, 1:40, 2:80, 3:160, 4:320, 5:240 MHz) |
| phy_nss_m1 | input | 3 | Spatial streams minus one |
| phy_rssi | input | 8 | RSSI at start |
| phy_airtime | input | 16 | Remaining packet time in µs at start |
| phy_end | input | 1 | Normal PPDU end pulse |
| phy_nap_abort | input | 1 | PPDU end by nap abort pulse |
| tick_us | input | 1 | One-microsecond tick |
| hdr_valid | input | 1 | MPDU header result valid |
| hdr_filter_pass | input | 1 | Header passed the address filter |
| hdr_directed | input | 1 | Header addressed to this station |
| hdr_ampdu | input | 1 | Reception is an A-MPDU |
| hdr_single_mpdu | input | 1 | Reception is a single MPDU |
| hdr_ftype | input | 3 | Frame type (0 data, 1 mgmt, 2 beacon, 3 RTS, 4 CTS/ACK/BA, 5 other) |
| hdr_retry | input | 1 | Retry bit of the header |
| hdr_more_data | input | 1 | More-data bit of the header |
| hdr_resp_exp | input | 1 | Response expected after this frame |
| fcs_ok | input | 1 | MPDU FCS passed |
| fcs_directed | input | 1 | MPDU with good FCS is addressed to this device |
| fcs_duration | input | 16 | Duration field of that MPDU |
| out_valid | output | 1 | Message valid |
| out_ready | input | 1 | Arbiter accepts message |
| out_msg | output | 64 | Status message, word 1 in [63:32] |

## Verification
The embedded assertions check, on every cycle, a set of properties. The output holds its value under backpressure. No second start or FCS message appears in a PPDU. No end message appears without a start. The airtime counter never rises between loads and stays at zero once there. The exchange time never falls below the airtime. Only the directed scenarios can show the contents of each message: the field positions, the filtered-out gating, the response-bit accumulation, exchange-time saturation, end priority within a cycle, and the ordering and overwrite rule in the holding register.

// File: rtl/rx_coex_pkg.sv
package rx_coex_pkg;
  localparam int TIME_W = 16;
  localparam int RATE_W = 5;
  localparam int BW_W   = 3;
  localparam int NSS_W  = 3;
  localparam int RSSI_W = 8;
  localparam int TYPE_W = 3;

  typedef enum logic [1:0] {
    CODE_START = 2'd0,
    CODE_FCS1  = 2'd1,
    CODE_END   = 2'd2,
    CODE_NAP   = 2'd3
  } code_e;

  typedef struct packed {
    logic [TIME_W-1:0] fes;
    logic [TIME_W-1:0] pkt;
    logic              more;
    logic              retry;
    logic [TYPE_W-1:0] ftype;
    logic [RSSI_W-1:0] rssi;
    logic [NSS_W-1:0]  nss;
    logic              rsvd;
    logic              directed;
    logic              ampdu;
    logic              filt;
    logic              single;
    logic [BW_W-1:0]   bw;
    logic [RATE_W-1:0] rate;
    logic              resp;
    code_e             code;
  } msg_t;

  localparam int MSG_W = $bits(msg_t);

  function automatic logic code_is_end(input code_e c);
    return (c == CODE_END) || (c == CODE_NAP);
  endfunction
endpackage

// File: rtl/rx_coex_time_track.sv
module rx_coex_time_track #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  input  logic         fcs_i,
  input  logic [W-1:0] fcs_dur_i,
  output logic [W-1:0] pkt_o,
  output logic [W-1:0] fes_o
);
  localparam logic [W-1:0] MAX_T = '1;

  logic [W-1:0] pkt_q, dur_q, dur_sel;
  logic         dur_vld_q, dur_use;
  logic [W:0]   sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_q     <= '0;
      dur_q     <= '0;
      dur_vld_q <= 1'b0;
    end else if (load_i) begin
      pkt_q     <= load_val_i;
      dur_q     <= '0;
      dur_vld_q <= 1'b0;
    end else begin
      if (tick_i && pkt_q != '0) pkt_q <= pkt_q - 1'b1;
      if (fcs_i && !dur_vld_q) begin
        dur_q     <= fcs_dur_i;
        dur_vld_q <= 1'b1;
      end
    end
  end

  always_comb begin
    dur_sel = dur_vld_q ? dur_q : fcs_dur_i;
    dur_use = dur_vld_q | fcs_i;
    sum     = {1'b0, pkt_q} + {1'b0, dur_sel};
    fes_o   = dur_use ? (sum[W] ? MAX_T : sum[W-1:0]) : pkt_q;
    pkt_o   = pkt_q;
  end

  // R7
  pkt_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (pkt_q <= $past(pkt_q)));
  // R7
  pkt_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && pkt_q == '0) |=> (pkt_q == '0));
  // R8
  fes_above_pkt_chk: assert property (@(posedge clk) disable iff (rst)
    fes_o >= pkt_o);
endmodule

// File: rtl/rx_coex_seq.sv
module rx_coex_seq
  import rx_coex_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_report_filtered_i,
  input  logic              phy_start_i,
  input  logic [RATE_W-1:0] phy_rate_i,
  input  logic [BW_W-1:0]   phy_bw_i,
  input  logic [NSS_W-1:0]  phy_nss_i,
  input  logic [RSSI_W-1:0] phy_rssi_i,
  input  logic              phy_end_i,
  input  logic              phy_nap_i,
  input  logic              hdr_valid_i,
  input  logic              hdr_filter_i,
  input  logic              hdr_directed_i,
  input  logic              hdr_ampdu_i,
  input  logic              hdr_single_i,
  input  logic [TYPE_W-1:0] hdr_ftype_i,
  input  logic              hdr_retry_i,
  input  logic              hdr_more_i,
  input  logic              hdr_resp_i,
  input  logic              fcs_ok_i,
  input  logic              fcs_directed_i,
  input  logic [TIME_W-1:0] pkt_i,
  input  logic [TIME_W-1:0] fes_i,
  output logic              load_o,
  output logic              fcs_evt_o,
  output logic              msg_valid_o,
  output msg_t              msg_o
);
  logic              active_q, start_sent_q, fcs_sent_q, resp_q;
  logic [RATE_W-1:0] rate_q;
  logic [BW_W-1:0]   bw_q;
  logic [NSS_W-1:0]  nss_q;
  logic [RSSI_W-1:0] rssi_q;
  logic              single_q, filt_q, amp_rep_q, dir_q, amp_raw_q, retry_q, more_q;
  logic [TYPE_W-1:0] ftype_q;

  logic end_any, hdr_in, start_go, fcs_go, end_emit;
  logic rep_filt, rep_amp, rep_dir;

  always_comb begin
    end_any   = active_q & (phy_end_i | phy_nap_i);
    hdr_in    = hdr_filter_i & hdr_directed_i;
    start_go  = active_q & hdr_valid_i & ~start_sent_q & ~end_any &
                (cfg_report_filtered_i | hdr_in);
    fcs_go    = active_q & fcs_ok_i & fcs_directed_i & start_sent_q &
                ~fcs_sent_q & amp_raw_q & ~end_any;
    end_emit  = end_any & start_sent_q;
    rep_filt  = cfg_report_filtered_i & hdr_filter_i;
    rep_amp   = cfg_report_filtered_i & hdr_ampdu_i;
    rep_dir   = cfg_report_filtered_i & hdr_directed_i;
    load_o    = phy_start_i;
    fcs_evt_o = active_q & fcs_ok_i & ~end_any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q     <= 1'b0;
      start_sent_q <= 1'b0;
      fcs_sent_q   <= 1'b0;
      resp_q       <= 1'b0;
    end else if (phy_start_i) begin
      active_q     <= 1'b1;
      start_sent_q <= 1'b0;
      fcs_sent_q   <= 1'b0;
      resp_q       <= 1'b0;
    end else if (end_any) begin
      active_q     <= 1'b0;
      start_sent_q <= 1'b0;
      fcs_sent_q   <= 1'b0;
      resp_q       <= 1'b0;
    end else begin
      if (start_go) start_sent_q <= 1'b1;
      if (fcs_go)   fcs_sent_q   <= 1'b1;
      if (active_q && hdr_valid_i && hdr_in && hdr_resp_i) resp_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (phy_start_i) begin
      rate_q <= phy_rate_i;
      bw_q   <= phy_bw_i;
      nss_q  <= phy_nss_i;
      rssi_q <= phy_rssi_i;
    end
    if (start_go && !phy_start_i) begin
      single_q  <= hdr_single_i;
      filt_q    <= rep_filt;
      amp_rep_q <= rep_amp;
      dir_q     <= rep_dir;
      amp_raw_q <= hdr_ampdu_i;
      ftype_q   <= hdr_ftype_i;
      retry_q   <= hdr_retry_i;
      more_q    <= hdr_more_i;
    end
  end

  always_comb begin
    msg_o      = '0;
    msg_o.fes  = fes_i;
    msg_o.pkt  = pkt_i;
    msg_o.rate = rate_q;
    msg_o.bw   = bw_q;
    msg_o.nss  = nss_q;
    msg_o.rssi = rssi_q;
    msg_o.rsvd = 1'b0;
    if (start_go) begin
      msg_o.code     = CODE_START;
      msg_o.resp     = 1'b0;
      msg_o.single   = hdr_single_i;
      msg_o.filt     = rep_filt;
      msg_o.ampdu    = rep_amp;
      msg_o.directed = rep_dir;
      msg_o.ftype    = hdr_ftype_i;
      msg_o.retry    = hdr_retry_i;
      msg_o.more     = hdr_more_i;
    end else begin
      msg_o.code     = end_emit ? (phy_nap_i ? CODE_NAP : CODE_END) : CODE_FCS1;
      msg_o.resp     = resp_q;
      msg_o.single   = single_q;
      msg_o.filt     = filt_q;
      msg_o.ampdu    = amp_rep_q;
      msg_o.directed = dir_q;
      msg_o.ftype    = ftype_q;
      msg_o.retry    = retry_q;
      msg_o.more     = more_q;
    end
    msg_valid_o = (start_go | fcs_go | end_emit) & ~phy_start_i;
  end

  // R2
  start_once_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && msg_o.code == CODE_START) |-> !start_sent_q);
  // R6
  fcs_once_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && msg_o.code == CODE_FCS1) |-> (!fcs_sent_q && amp_raw_q && start_sent_q));
  // R9
  end_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && code_is_end(msg_o.code)) |-> start_sent_q);
endmodule

// File: rtl/rx_coex_out_slot.sv
module rx_coex_out_slot #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         new_valid_i,
  input  logic         new_is_end_i,
  input  logic [W-1:0] new_msg_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] msg_o
);
  logic         out_v, hold_v, pop;
  logic [W-1:0] out_m, hold_m;

  assign pop = out_v & ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v  <= 1'b0;
      hold_v <= 1'b0;
    end else if (!out_v || pop) begin
      if (hold_v) begin
        out_v  <= 1'b1;
        hold_v <= new_valid_i;
      end else begin
        out_v  <= new_valid_i;
      end
    end else if (new_valid_i && (!hold_v || new_is_end_i)) begin
      hold_v <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!out_v || pop) begin
      if (hold_v) begin
        out_m <= hold_m;
        if (new_valid_i) hold_m <= new_msg_i;
      end else if (new_valid_i) begin
        out_m <= new_msg_i;
      end
    end else if (new_valid_i && (!hold_v || new_is_end_i)) begin
      hold_m <= new_msg_i;
    end
  end

  assign valid_o = out_v;
  assign msg_o   = out_m;

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(msg_o)));
  // R12
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !valid_o);
endmodule

// File: rtl/rx_coex_status_gen.sv
module rx_coex_status_gen
  import rx_coex_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_report_filtered,
  input  logic              phy_start,
  input  logic [RATE_W-1:0] phy_rate,
  input  logic [BW_W-1:0]   phy_bw,
  input  logic [NSS_W-1:0]  phy_nss_m1,
  input  logic [RSSI_W-1:0] phy_rssi,
  input  logic [TIME_W-1:0] phy_airtime,
  input  logic              phy_end,
  input  logic              phy_nap_abort,
  input  logic              tick_us,
  input  logic              hdr_valid,
  input  logic              hdr_filter_pass,
  input  logic              hdr_directed,
  input  logic              hdr_ampdu,
  input  logic              hdr_single_mpdu,
  input  logic [TYPE_W-1:0] hdr_ftype,
  input  logic              hdr_retry,
  input  logic              hdr_more_data,
  input  logic              hdr_resp_exp,
  input  logic              fcs_ok,
  input  logic              fcs_directed,
  input  logic [TIME_W-1:0] fcs_duration,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MSG_W-1:0]  out_msg
);
  logic [TIME_W-1:0] pkt, fes;
  logic              load, fcs_evt, msg_valid;
  msg_t              msg;

  rx_coex_time_track #(.W(TIME_W)) u_time (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_val_i (phy_airtime),
    .tick_i     (tick_us),
    .fcs_i      (fcs_evt),
    .fcs_dur_i  (fcs_duration),
    .pkt_o      (pkt),
    .fes_o      (fes)
  );

  rx_coex_seq u_seq (
    .clk                   (clk),
    .rst                   (rst),
    .cfg_report_filtered_i (cfg_report_filtered),
    .phy_start_i           (phy_start),
    .phy_rate_i            (phy_rate),
    .phy_bw_i              (phy_bw),
    .phy_nss_i             (phy_nss_m1),
    .phy_rssi_i            (phy_rssi),
    .phy_end_i             (phy_end),
    .phy_nap_i             (phy_nap_abort),
    .hdr_valid_i           (hdr_valid),
    .hdr_filter_i          (hdr_filter_pass),
    .hdr_directed_i        (hdr_directed),
    .hdr_ampdu_i           (hdr_ampdu),
    .hdr_single_i          (hdr_single_mpdu),
    .hdr_ftype_i           (hdr_ftype),
    .hdr_retry_i           (hdr_retry),
    .hdr_more_i            (hdr_more_data),
    .hdr_resp_i            (hdr_resp_exp),
    .fcs_ok_i              (fcs_ok),
    .fcs_directed_i        (fcs_directed),
    .pkt_i                 (pkt),
    .fes_i                 (fes),
    .load_o                (load),
    .fcs_evt_o             (fcs_evt),
    .msg_valid_o           (msg_valid),
    .msg_o                 (msg)
  );

  rx_coex_out_slot #(.W(MSG_W)) u_slot (
    .clk          (clk),
    .rst          (rst),
    .new_valid_i  (msg_valid),
    .new_is_end_i (code_is_end(msg.code)),
    .new_msg_i    (msg),
    .ready_i      (out_ready),
    .valid_o      (out_valid),
    .msg_o        (out_msg)
  );
endmodule

// File: tb/rx_coex_status_gen_tb.sv
module rx_coex_status_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_report_filtered = 1'b0;
  logic phy_start = 1'b0, phy_end = 1'b0, phy_nap_abort = 1'b0, tick_us = 1'b0;
  logic [4:0] phy_rate = '0;
  logic [2:0] phy_bw = '0, phy_nss_m1 = '0, hdr_ftype = '0;
  logic [7:0] phy_rssi = '0;
  logic [15:0] phy_airtime = '0, fcs_duration = '0;
  logic hdr_valid = 1'b0, hdr_filter_pass = 1'b0, hdr_directed = 1'b0, hdr_ampdu = 1'b0;
  logic hdr_single_mpdu = 1'b0, hdr_retry = 1'b0, hdr_more_data = 1'b0, hdr_resp_exp = 1'b0;
  logic fcs_ok = 1'b0, fcs_directed = 1'b0, out_ready = 1'b1;
  logic out_valid;
  logic [63:0] out_msg;

  int n_chk = 0;
  int n_fail = 0;
  logic [4:0] g_rate;
  logic [2:0] g_bw, g_nss;
  logic [7:0] g_rssi;

  always #2 clk = ~clk;

  rx_coex_status_gen u_dut (
    .clk(clk), .rst(rst), .cfg_report_filtered(cfg_report_filtered),
    .phy_start(phy_start), .phy_rate(phy_rate), .phy_bw(phy_bw),
    .phy_nss_m1(phy_nss_m1), .phy_rssi(phy_rssi), .phy_airtime(phy_airtime),
    .phy_end(phy_end), .phy_nap_abort(phy_nap_abort), .tick_us(tick_us),
    .hdr_valid(hdr_valid), .hdr_filter_pass(hdr_filter_pass), .hdr_directed(hdr_directed),
    .hdr_ampdu(hdr_ampdu), .hdr_single_mpdu(hdr_single_mpdu), .hdr_ftype(hdr_ftype),
    .hdr_retry(hdr_retry), .hdr_more_data(hdr_more_data), .hdr_resp_exp(hdr_resp_exp),
    .fcs_ok(fcs_ok), .fcs_directed(fcs_directed), .fcs_duration(fcs_duration),
    .out_valid(out_valid), .out_ready(out_ready), .out_msg(out_msg)
  );

  function automatic logic [63:0] mk(input logic [1:0] code, input logic resp,
      input logic filt, input logic amp, input logic dir, input logic single,
      input logic [2:0] ft, input logic retry, input logic more,
      input logic [15:0] pkt, input logic [15:0] fes);
    return {fes, pkt, more, retry, ft, g_rssi, g_nss, 1'b0, dir, amp, filt, single,
            g_bw, g_rate, resp, code};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_msg(input string req, input logic [63:0] exp);
    n_chk++;
    if (out_valid !== 1'b1 || out_msg !== exp) begin
      n_fail++;
      $display("FAIL %s: actual valid=%b msg=%h expected valid=1 msg=%h", req, out_valid, out_msg, exp);
    end
  endtask

  task automatic expect_none(input string req);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: actual valid=%b msg=%h expected valid=0", req, out_valid, out_msg);
    end
  endtask

  task automatic do_start(input logic [15:0] t, input logic [4:0] r, input logic [2:0] b,
      input logic [2:0] s, input logic [7:0] q);
    phy_start = 1'b1; phy_airtime = t; phy_rate = r; phy_bw = b; phy_nss_m1 = s; phy_rssi = q;
    g_rate = r; g_bw = b; g_nss = s; g_rssi = q;
    step();
    phy_start = 1'b0;
  endtask

  task automatic do_hdr(input logic filt, input logic dir, input logic amp, input logic single,
      input logic [2:0] ft, input logic retry, input logic more, input logic resp);
    hdr_valid = 1'b1; hdr_filter_pass = filt; hdr_directed = dir; hdr_ampdu = amp;
    hdr_single_mpdu = single; hdr_ftype = ft; hdr_retry = retry; hdr_more_data = more;
    hdr_resp_exp = resp;
    step();
    hdr_valid = 1'b0;
  endtask

  task automatic do_fcs(input logic dir, input logic [15:0] dur);
    fcs_ok = 1'b1; fcs_directed = dir; fcs_duration = dur;
    step();
    fcs_ok = 1'b0;
  endtask

  task automatic do_end(input logic nrm, input logic nap);
    phy_end = nrm; phy_nap_abort = nap;
    step();
    phy_end = 1'b0; phy_nap_abort = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    tick_us = 1'b1;
    repeat (n) step();
    tick_us = 1'b0;
  endtask

  task automatic t_reset();
    expect_none("R12 reset idle");
  endtask

  task automatic t_basic();
    cfg_report_filtered = 1'b0;
    do_start(16'd1000, 5'h13, 3'd4, 3'd2, 8'hA5);
    expect_none("R2 no message at bare start");
    do_hdr(1, 1, 0, 1, 3'd3, 1, 0, 1);
    expect_msg("R2 R3 R4 start message", mk(2'd0, 0, 0, 0, 0, 1, 3'd3, 1, 0, 16'd1000, 16'd1000));
    do_hdr(1, 1, 0, 1, 3'd3, 1, 0, 1);
    expect_none("R2 second header silent");
    do_end(1, 0);
    expect_msg("R1 R3 end message", mk(2'd2, 1, 0, 0, 0, 1, 3'd3, 1, 0, 16'd1000, 16'd1000));
    do_end(1, 0);
    expect_none("R9 end after close ignored");
    do_hdr(1, 1, 0, 1, 3'd3, 1, 0, 1);
    expect_none("R9 header after close ignored");
  endtask

  task automatic t_ampdu();
    do_start(16'd500, 5'h07, 3'd1, 3'd0, 8'h3C);
    do_hdr(1, 1, 1, 0, 3'd0, 0, 1, 0);
    expect_msg("R2 R4 A-MPDU start", mk(2'd0, 0, 0, 0, 0, 0, 3'd0, 0, 1, 16'd500, 16'd500));
    do_fcs(1, 16'd200);
    expect_msg("R6 R8 first FCS", mk(2'd1, 0, 0, 0, 0, 0, 3'd0, 0, 1, 16'd500, 16'd700));
    do_fcs(1, 16'd50);
    expect_none("R6 second FCS silent");
    do_end(0, 1);
    expect_msg("R1 nap end", mk(2'd3, 0, 0, 0, 0, 0, 3'd0, 0, 1, 16'd500, 16'd700));
  endtask

  task automatic t_fcs_undirected();
    do_start(16'd300, 5'h1F, 3'd5, 3'd7, 8'h80);
    do_hdr(1, 1, 1, 0, 3'd4, 1, 1, 1);
    expect_msg("R4 start fields", mk(2'd0, 0, 0, 0, 0, 0, 3'd4, 1, 1, 16'd300, 16'd300));
    do_fcs(0, 16'd40);
    expect_none("R6 undirected FCS silent");
    do_fcs(1, 16'd90);
    expect_msg("R6 R8 R3 FCS after undirected", mk(2'd1, 1, 0, 0, 0, 0, 3'd4, 1, 1, 16'd300, 16'd340));
    do_end(1, 0);
    expect_msg("R8 end keeps first duration", mk(2'd2, 1, 0, 0, 0, 0, 3'd4, 1, 1, 16'd300, 16'd340));
  endtask

  task automatic t_non_ampdu();
    do_start(16'd800, 5'h02, 3'd2, 3'd1, 8'h11);
    do_hdr(1, 1, 0, 1, 3'd1, 0, 0, 0);
    expect_msg("R2 non-A-MPDU start", mk(2'd0, 0, 0, 0, 0, 1, 3'd1, 0, 0, 16'd800, 16'd800));
    do_fcs(1, 16'd100);
    expect_none("R6 no FCS message for single MPDU");
    do_end(1, 0);
    expect_msg("R8 end fes includes duration", mk(2'd2, 0, 0, 0, 0, 1, 3'd1, 0, 0, 16'd800, 16'd900));
  endtask

  task automatic t_time();
    do_start(16'hFFF0, 5'h0A, 3'd3, 3'd3, 8'h44);
    do_hdr(1, 1, 1, 0, 3'd2, 0, 0, 0);
    expect_msg("R7 start airtime", mk(2'd0, 0, 0, 0, 0, 0, 3'd2, 0, 0, 16'hFFF0, 16'hFFF0));
    do_fcs(1, 16'h0100);
    expect_msg("R8 saturated exchange time", mk(2'd1, 0, 0, 0, 0, 0, 3'd2, 0, 0, 16'hFFF0, 16'hFFFF));
    do_ticks(2);
    expect_none("R7 ticks silent");
    do_end(1, 0);
    expect_msg("R7 R8 after two ticks", mk(2'd2, 0, 0, 0, 0, 0, 3'd2, 0, 0, 16'hFFEE, 16'hFFFF));
    do_start(16'd2, 5'h0A, 3'd3, 3'd3, 8'h44);
    do_hdr(1, 1, 0, 0, 3'd0, 0, 0, 0);
    expect_msg("R7 short airtime start", mk(2'd0, 0, 0, 0, 0, 0, 3'd0, 0, 0, 16'd2, 16'd2));
    do_ticks(4);
    do_end(1, 0);
    expect_msg("R7 airtime floors at zero", mk(2'd2, 0, 0, 0, 0, 0, 3'd0, 0, 0, 16'd0, 16'd0));
  endtask

  task automatic t_filtered();
    cfg_report_filtered = 1'b1;
    do_start(16'd64, 5'h05, 3'd0, 3'd1, 8'h22);
    do_hdr(0, 0, 1, 0, 3'd1, 0, 0, 1);
    expect_msg("R5 filtered-out frame reported", mk(2'd0, 0, 0, 1, 0, 0, 3'd1, 0, 0, 16'd64, 16'd64));
    do_end(1, 0);
    expect_msg("R5 R3 end of filtered-out", mk(2'd2, 0, 0, 1, 0, 0, 3'd1, 0, 0, 16'd64, 16'd64));
    do_start(16'd64, 5'h05, 3'd0, 3'd1, 8'h22);
    do_hdr(1, 1, 1, 0, 3'd0, 0, 0, 0);
    expect_msg("R5 fields filled", mk(2'd0, 0, 1, 1, 1, 0, 3'd0, 0, 0, 16'd64, 16'd64));
    do_end(1, 0);
    expect_msg("R5 end fields filled", mk(2'd2, 0, 1, 1, 1, 0, 3'd0, 0, 0, 16'd64, 16'd64));
    cfg_report_filtered = 1'b0;
    do_start(16'd64, 5'h05, 3'd0, 3'd1, 8'h22);
    do_hdr(0, 1, 0, 0, 3'd0, 0, 0, 0);
    expect_none("R2 filter-fail header silent");
    do_hdr(1, 0, 0, 0, 3'd0, 0, 0, 0);
    expect_none("R2 undirected header silent");
    do_end(1, 0);
    expect_none("R9 end without start silent");
    do_start(16'd70, 5'h05, 3'd0, 3'd1, 8'h22);
    do_hdr(1, 1, 0, 0, 3'd5, 0, 0, 0);
    expect_msg("R9 flags cleared for new PPDU", mk(2'd0, 0, 0, 0, 0, 0, 3'd5, 0, 0, 16'd70, 16'd70));
    do_end(1, 0);
    expect_msg("R9 end after new start", mk(2'd2, 0, 0, 0, 0, 0, 3'd5, 0, 0, 16'd70, 16'd70));
  endtask

  task automatic t_priority();
    do_start(16'd120, 5'h09, 3'd2, 3'd0, 8'h55);
    do_hdr(1, 1, 1, 0, 3'd0, 0, 0, 0);
    expect_msg("R13 setup start", mk(2'd0, 0, 0, 0, 0, 0, 3'd0, 0, 0, 16'd120, 16'd120));
    fcs_ok = 1'b1; fcs_directed = 1'b1; fcs_duration = 16'd10;
    do_end(1, 0);
    fcs_ok = 1'b0;
    expect_msg("R13 end wins over FCS", mk(2'd2, 0, 0, 0, 0, 0, 3'd0, 0, 0, 16'd120, 16'd120));
    step();
    expect_none("R13 no FCS message after end");
    do_start(16'd120, 5'h09, 3'd2, 3'd0, 8'h55);
    do_hdr(1, 1, 1, 0, 3'd0, 0, 0, 0);
    step();
    do_end(1, 1);
    expect_msg("R1 both end pulses give nap code", mk(2'd3, 0, 0, 0, 0, 0, 3'd0, 0, 0, 16'd120, 16'd120));
  endtask

  task automatic t_backpressure();
    logic [63:0] a, c;
    step();
    out_ready = 1'b0;
    do_start(16'd40, 5'h11, 3'd1, 3'd1, 8'h66);
    do_hdr(1, 1, 1, 0, 3'd0, 0, 0, 0);
    a = mk(2'd0, 0, 0, 0, 0, 0, 3'd0, 0, 0, 16'd40, 16'd40);
    c = mk(2'd2, 0, 0, 0, 0, 0, 3'd0, 0, 0, 16'd40, 16'd40);
    expect_msg("R10 first message", a);
    do_fcs(1, 16'd0);
    expect_msg("R10 held during FCS", a);
    do_end(1, 0);
    expect_msg("R10 held during end", a);
    do_start(16'd9, 5'h11, 3'd1, 3'd1, 8'h66);
    do_hdr(1, 1, 0, 0, 3'd0, 0, 0, 0);
    expect_msg("R10 held during new start", a);
    g_nss = 3'd1;
    out_ready = 1'b1;
    step();
    expect_msg("R11 end replaced FCS in holding", c);
    step();
    expect_none("R11 non-end message dropped");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_basic();
    t_ampdu();
    t_fcs_undirected();
    t_non_ampdu();
    t_time();
    t_filtered();
    t_priority();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule